// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operand fields of one memory instruction into a memory access. It computes the effective address, issues a single-cycle request to a synchronous memory port, and hands back the results. For a load, that is the loaded word for the destination register. For any op, it is the updated base value with its write enable.

The offset can come from three sources:
- a 12-bit unsigned constant;
- an offset register value;
- the offset register value shifted left by a given amount.

The offset is added to or subtracted from the base. The base is normally a register value. It can instead be the instruction address advanced by 8, for PC-relative access.

Three index modes decide which value drives the address and whether the base is rewritten:
- pre-index without writeback;
- pre-index with writeback;
- post-index, which always writes back.

The surrounding pipeline presents an op with a valid strobe while the unit is idle. It then waits for the done pulse. The register file and the memory array sit outside the block.

Top module: `lsagu_top`

## Requirements
- R1: `op_off_sel` picks the offset: 0 gives `op_imm` zero-extended, 1 gives `op_offreg`, and 2 or 3 give `op_offreg` shifted left by `op_shamt`. The offset register value is only read.
- R2: In pre-index mode (`op_post`=0) `mem_addr` is base+offset, or base-offset when `op_sub`=1, wrapping modulo 2^32.
- R3: In pre-index mode with `op_wb`=0, `base_we` stays low at done.
- R4: In pre-index mode with `op_wb`=1, `base_we` is high at done and `base_new` equals the address used for the access.
- R5: In post-index mode (`op_post`=1), `mem_addr` is the unmodified base. `base_new` is base±offset and `base_we` is high whatever `op_wb` holds.
- R6: With `op_pcrel`=1 the base is `op_pc`+8, and `base_we` is low in every mode.
- R7: A load (`op_store`=0) raises `rd_we` at done, with `rd_data` being the word read at `mem_addr` and `rd_idx` being `op_dst`. A store raises `mem_we` with `mem_wdata`=`op_sdata` during the request and never raises `rd_we`.
- R8: `mem_req` is high for exactly the one cycle after the accepting edge. `done` pulses for one cycle, two cycles after the request. `base_idx` equals `op_base` at done.
- R9: `busy` is high from the cycle after acceptance through the done cycle. An `op_valid` seen while `busy` is high is ignored.
- R10: When a load's `op_dst` equals `op_base` and writeback is active, `rd_we` stays high and `base_we` is forced low.
- R11: After reset, `busy`, `mem_req`, `mem_we`, `done`, `rd_we` and `base_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Op present; taken only when idle |
| op_store | input | 1 | 1 = store, 0 = load |
| op_off_sel | input | 2 | Offset source select |
| op_shamt | input | 5 | Left shift applied to the offset register |
| op_sub | input | 1 | Subtract the offset instead of adding it |
| op_post | input | 1 | Post-index mode |
| op_wb | input | 1 | Writeback request in pre-index mode |
| op_pcrel | input | 1 | Use instruction address + 8 as base |
| op_base | input | 4 | Base register number |
| op_dst | input | 4 | Destination/source register number |
| op_baseval | input | 32 | Base register value |
| op_pc | input | 32 | Instruction address |
| op_imm | input | 12 | Immediate offset |
| op_offreg | input | 32 | Offset register value |
| op_sdata | input | 32 | Store data |
| busy | output | 1 | Op in flight |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| done | output | 1 | Result cycle |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register number |
| rd_data | output | 32 | Loaded word |
| base_we | output | 1 | Base register write enable |
| base_idx | output | 4 | Base register number to update |
| base_new | output | 32 | Updated base value |

## Verification
The edge that accepts an op puts the address, write enable and store data on the memory port. The bench checks these at the falling edge right after it. One falling edge later it confirms that the request has dropped. The memory answers one edge after that. `done`, the load data and the base writeback signals are due the edge after the answer, so they are sampled at the third falling edge after the op was driven. The fourth falling edge then confirms that `busy` and `done` are low again. Some ops carry a stray `op_valid` during the busy window. A wrongly accepted op would overwrite the held results, and the done-cycle comparison would show it.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  typedef enum logic [1:0] {
    OFF_IMM  = 2'd0,
    OFF_REG  = 2'd1,
    OFF_SHL  = 2'd2,
    OFF_SHL3 = 2'd3
  } off_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } lsagu_state_e;

endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset
  import lsagu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = 5
) (
  input  logic [1:0]       sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  oreg,
  input  logic [SHW-1:0]   shamt,
  output logic [XLEN-1:0]  off
);

  localparam int PAD_W = XLEN - IMM_W;

  always_comb begin
    case (off_sel_e'(sel))
      OFF_IMM: off = {{PAD_W{1'b0}}, imm};
      OFF_REG: off = oreg;
      default: off = oreg << shamt;
    endcase
  end

endmodule

// File: rtl/lsagu_calc.sv
module lsagu_calc #(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 4,
  parameter int PC_AHEAD = 8
) (
  input  logic [XLEN-1:0]   base_reg,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   off,
  input  logic              sub,
  input  logic              post,
  input  logic              wb,
  input  logic              pcrel,
  input  logic              is_load,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]   addr,
  output logic [XLEN-1:0]   new_base,
  output logic              bwe
);

  localparam logic [XLEN-1:0] PC_ADD = XLEN'(PC_AHEAD);

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] sum;
  logic            wb_want;
  logic            clash;

  always_comb begin
    base_eff = pcrel ? (pc + PC_ADD) : base_reg;
    sum      = sub ? (base_eff - off) : (base_eff + off);
    addr     = post ? base_eff : sum;
    new_base = sum;
    wb_want  = post | wb;
    clash    = is_load && (dst_idx == base_idx);
    bwe      = wb_want && !pcrel && !clash;
  end

endmodule

// File: rtl/lsagu_seq.sv
module lsagu_seq
  import lsagu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  output logic accept,
  output logic busy,
  output logic in_req,
  output logic in_wait,
  output logic in_resp
);

  lsagu_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (op_valid) state_nx = ST_REQ;
      ST_REQ:  state_nx = ST_WAIT;
      ST_WAIT: state_nx = ST_RESP;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign accept  = (state == ST_IDLE) && op_valid;
  assign busy    = (state != ST_IDLE);
  assign in_req  = (state == ST_REQ);
  assign in_wait = (state == ST_WAIT);
  assign in_resp = (state == ST_RESP);

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 12,
  parameter int RIDX_W   = 4,
  parameter int SHW      = $clog2(XLEN),
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_store,
  input  logic [1:0]        op_off_sel,
  input  logic [SHW-1:0]    op_shamt,
  input  logic              op_sub,
  input  logic              op_post,
  input  logic              op_wb,
  input  logic              op_pcrel,
  input  logic [RIDX_W-1:0] op_base,
  input  logic [RIDX_W-1:0] op_dst,
  input  logic [XLEN-1:0]   op_baseval,
  input  logic [XLEN-1:0]   op_pc,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [XLEN-1:0]   op_offreg,
  input  logic [XLEN-1:0]   op_sdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              done,
  output logic              rd_we,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic              base_we,
  output logic [RIDX_W-1:0] base_idx,
  output logic [XLEN-1:0]   base_new
);

  logic            accept, in_req, in_wait, in_resp;
  logic [XLEN-1:0] off_c, addr_c, nbase_c;
  logic            bwe_c;

  logic [XLEN-1:0]   addr_r, nbase_r, wdata_r, rdata_r;
  logic              bwe_r, store_r;
  logic [RIDX_W-1:0] dst_r, bidx_r;

  lsagu_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .SHW(SHW)) u_off (
    .sel   (op_off_sel),
    .imm   (op_imm),
    .oreg  (op_offreg),
    .shamt (op_shamt),
    .off   (off_c)
  );

  lsagu_calc #(.XLEN(XLEN), .RIDX_W(RIDX_W), .PC_AHEAD(PC_AHEAD)) u_calc (
    .base_reg (op_baseval),
    .pc       (op_pc),
    .off      (off_c),
    .sub      (op_sub),
    .post     (op_post),
    .wb       (op_wb),
    .pcrel    (op_pcrel),
    .is_load  (!op_store),
    .base_idx (op_base),
    .dst_idx  (op_dst),
    .addr     (addr_c),
    .new_base (nbase_c),
    .bwe      (bwe_c)
  );

  lsagu_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .accept   (accept),
    .busy     (busy),
    .in_req   (in_req),
    .in_wait  (in_wait),
    .in_resp  (in_resp)
  );

  // Op capture at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_r  <= '0;
      nbase_r <= '0;
      wdata_r <= '0;
      bwe_r   <= 1'b0;
      store_r <= 1'b0;
      dst_r   <= '0;
      bidx_r  <= '0;
    end else if (accept) begin
      addr_r  <= addr_c;
      nbase_r <= nbase_c;
      wdata_r <= op_sdata;
      bwe_r   <= bwe_c;
      store_r <= op_store;
      dst_r   <= op_dst;
      bidx_r  <= op_base;
    end
  end

  // Memory answer is valid while waiting; hold it for the result cycle
  always_ff @(posedge clk) begin
    if (rst)          rdata_r <= '0;
    else if (in_wait) rdata_r <= mem_rdata;
  end

  assign mem_req   = in_req;
  assign mem_we    = in_req && store_r;
  assign mem_addr  = addr_r;
  assign mem_wdata = wdata_r;
  assign done      = in_resp;
  assign rd_we     = in_resp && !store_r;
  assign rd_idx    = dst_r;
  assign rd_data   = rdata_r;
  assign base_we   = in_resp && bwe_r;
  assign base_idx  = bidx_r;
  assign base_new  = nbase_r;

endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int RIDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              done,
  input logic              rd_we,
  input logic              base_we,
  input logic [RIDX_W-1:0] rd_idx,
  input logic [RIDX_W-1:0] base_idx
);

  assert_req_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !busy) |=> mem_req);

  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  assert_done_two_after_req_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ##2 done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_over_done_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  assert_busy_starts_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_req);

  assert_write_in_req_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  assert_store_no_rdwe_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ##2 !rd_we);

  assert_load_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_we && base_we) |-> (rd_idx != base_idx));

  assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !done && !rd_we && !base_we));

endmodule

bind lsagu_top lsagu_chk #(.RIDX_W(RIDX_W)) u_lsagu_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .done     (done),
  .rd_we    (rd_we),
  .base_we  (base_we),
  .rd_idx   (rd_idx),
  .base_idx (base_idx)
);

// File: tb/tb_lsagu_top.sv
module tb_lsagu_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_store = 1'b0, op_sub = 1'b0, op_post = 1'b0;
  logic        op_wb = 1'b0, op_pcrel = 1'b0;
  logic [1:0]  op_off_sel = 2'd0;
  logic [4:0]  op_shamt = '0;
  logic [3:0]  op_base = '0, op_dst = '0;
  logic [31:0] op_baseval = '0, op_pc = '0, op_offreg = '0, op_sdata = '0;
  logic [11:0] op_imm = '0;
  logic        busy, mem_req, mem_we, done, rd_we, base_we;
  logic [31:0] mem_addr, mem_wdata, rd_data, base_new;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  rd_idx, base_idx;

  int checks = 0;
  int failures = 0;

  logic [31:0] mem [256];

  always #10 clk = ~clk;

  lsagu_top dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
    .op_off_sel(op_off_sel), .op_shamt(op_shamt), .op_sub(op_sub),
    .op_post(op_post), .op_wb(op_wb), .op_pcrel(op_pcrel),
    .op_base(op_base), .op_dst(op_dst), .op_baseval(op_baseval),
    .op_pc(op_pc), .op_imm(op_imm), .op_offreg(op_offreg),
    .op_sdata(op_sdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .base_we(base_we), .base_idx(base_idx), .base_new(base_new)
  );

  // Synchronous memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_off(input logic [1:0] sel, input logic [11:0] imm,
                                        input logic [31:0] oreg, input logic [4:0] sh);
    if (sel == 2'd0)      return {20'd0, imm};
    else if (sel == 2'd1) return oreg;
    else                  return oreg << sh;
  endfunction

  function automatic logic [31:0] f_base(input logic pcrel, input logic [31:0] b,
                                         input logic [31:0] pc);
    return pcrel ? pc + 32'd8 : b;
  endfunction

  function automatic logic [31:0] f_sum(input logic [31:0] b, input logic [31:0] o,
                                        input logic sub);
    return sub ? b - o : b + o;
  endfunction

  function automatic logic f_bwe(input logic post, input logic wb, input logic pcrel,
                                 input logic store, input logic [3:0] bi, input logic [3:0] di);
    if (pcrel) return 1'b0;
    if (!(post || wb)) return 1'b0;
    if (!store && (bi == di)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_op(input string tag, input logic store, input logic [1:0] sel,
                        input logic [4:0] sh, input logic sub, input logic post,
                        input logic wb, input logic pcrel, input logic [3:0] bi,
                        input logic [3:0] di, input logic [31:0] bv,
                        input logic [31:0] pc, input logic [11:0] imm,
                        input logic [31:0] oreg, input logic [31:0] sd,
                        input logic stray);
    logic [31:0] b, o, s, ea, ld;
    logic        bw;
    b  = f_base(pcrel, bv, pc);
    o  = f_off(sel, imm, oreg, sh);
    s  = f_sum(b, o, sub);
    ea = post ? b : s;
    bw = f_bwe(post, wb, pcrel, store, bi, di);
    ld = mem[ea[9:2]];
    op_valid = 1'b1; op_store = store; op_off_sel = sel; op_shamt = sh;
    op_sub = sub; op_post = post; op_wb = wb; op_pcrel = pcrel;
    op_base = bi; op_dst = di; op_baseval = bv; op_pc = pc; op_imm = imm;
    op_offreg = oreg; op_sdata = sd;
    @(negedge clk);
    check({tag, " R8"}, "mem_req", {31'd0, mem_req}, 32'd1);
    check({tag, " R9"}, "busy", {31'd0, busy}, 32'd1);
    check({tag, " R2/R5"}, "mem_addr", mem_addr, ea);
    check({tag, " R7"}, "mem_we", {31'd0, mem_we}, {31'd0, store});
    if (store) check({tag, " R7"}, "mem_wdata", mem_wdata, sd);
    if (stray) begin
      // R9: an op presented while busy must be ignored
      op_valid = 1'b1; op_baseval = ~bv; op_imm = ~imm; op_offreg = ~oreg;
      op_post = ~post; op_wb = ~wb; op_store = ~store; op_base = ~bi;
    end else begin
      op_valid = 1'b0;
    end
    @(negedge clk);
    op_valid = 1'b0;
    check({tag, " R8"}, "mem_req_drop", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    check({tag, " R8"}, "done", {31'd0, done}, 32'd1);
    check({tag, " R7"}, "rd_we", {31'd0, rd_we}, {31'd0, !store});
    check({tag, " R7"}, "rd_idx", {28'd0, rd_idx}, {28'd0, di});
    if (!store) check({tag, " R7"}, "rd_data", rd_data, ld);
    check({tag, " R3/R4/R5/R6/R10"}, "base_we", {31'd0, base_we}, {31'd0, bw});
    check({tag, " R8"}, "base_idx", {28'd0, base_idx}, {28'd0, bi});
    if (bw) check({tag, " R4/R5"}, "base_new", base_new, s);
    @(negedge clk);
    check({tag, " R9"}, "busy_end", {31'd0, busy}, 32'd0);
    check({tag, " R8"}, "done_end", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h00005A5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11", "busy", {31'd0, busy}, 32'd0);
    check("R11", "mem_req", {31'd0, mem_req}, 32'd0);
    check("R11", "mem_we", {31'd0, mem_we}, 32'd0);
    check("R11", "done", {31'd0, done}, 32'd0);
    check("R11", "rd_we", {31'd0, rd_we}, 32'd0);
    check("R11", "base_we", {31'd0, base_we}, 32'd0);

    // R6: PC-relative, pre-index, no writeback
    run_op("R6 pc4000", 0, 2'd0, 5'd0, 0, 0, 0, 1, 4'd1, 4'd2, 32'h0, 32'h4000, 12'h078, 0, 0, 0);
    run_op("R6 pc4004", 0, 2'd0, 5'd0, 0, 0, 0, 1, 4'd1, 4'd2, 32'h0, 32'h4004, 12'h080, 0, 0, 0);
    // R6: writeback and post requested, still no base write
    run_op("R6 pcpost", 0, 2'd0, 5'd0, 0, 1, 1, 1, 4'd3, 4'd4, 32'h0, 32'h4000, 12'h010, 0, 0, 0);
    // R1: shifted register offset, R3: no writeback
    run_op("R1 R3 shl2", 0, 2'd2, 5'd2, 0, 0, 0, 0, 4'd5, 4'd6, 32'h1000, 0, 0, 32'd7, 0, 0);
    // R1: sel 3 behaves as shifted
    run_op("R1 sel3", 0, 2'd3, 5'd4, 0, 0, 1, 0, 4'd5, 4'd6, 32'h2000, 0, 0, 32'd3, 0, 0);
    // R2: wrap on add and on subtract
    run_op("R2 R4 wrap", 0, 2'd0, 5'd0, 0, 0, 1, 0, 4'd7, 4'd8, 32'hFFFFFFFC, 0, 12'h008, 0, 0, 0);
    run_op("R2 sub", 0, 2'd1, 5'd0, 1, 0, 1, 0, 4'd7, 4'd8, 32'h10, 0, 0, 32'h20, 0, 0);
    // R5: post-index with wb low still writes back
    run_op("R5 post", 0, 2'd0, 5'd0, 0, 1, 0, 0, 4'd9, 4'd10, 32'h300, 0, 12'h004, 0, 0, 0);
    // R7: store, then load it back
    run_op("R7 store", 1, 2'd0, 5'd0, 0, 0, 0, 0, 4'd1, 4'd2, 32'h40, 0, 12'h008, 0, 32'hCAFEF00D, 0);
    run_op("R7 load", 0, 2'd0, 5'd0, 0, 0, 0, 0, 4'd1, 4'd3, 32'h48, 0, 12'h000, 0, 0, 0);
    check("R7", "stored_word", rd_data, 32'hCAFEF00D);
    // R10: load dst == base with writeback
    run_op("R10 clash", 0, 2'd0, 5'd0, 0, 0, 1, 0, 4'd4, 4'd4, 32'h80, 0, 12'h004, 0, 0, 0);
    run_op("R10 clashpost", 0, 2'd1, 5'd0, 0, 1, 0, 0, 4'd4, 4'd4, 32'h80, 0, 0, 32'h4, 0, 0);
    // R10 contrast: a store with dst == base still writes back
    run_op("R10 store", 1, 2'd0, 5'd0, 0, 0, 1, 0, 4'd4, 4'd4, 32'h90, 0, 12'h004, 0, 32'h1, 0);
    // R9: stray op while busy
    run_op("R9 stray", 0, 2'd0, 5'd0, 0, 0, 1, 0, 4'd2, 4'd9, 32'h100, 0, 12'h00C, 0, 0, 1);
    @(negedge clk);
    check("R9", "no_stray_req", {31'd0, mem_req}, 32'd0);

    void'($urandom(32'd20240611));
    for (int n = 0; n < 300; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      run_op("rand", rv[0], rv[2:1], rv[7:3], rv[8], rv[9], rv[10], (rv[13:11] == 3'd0),
             rv[17:14], (rv[18] ? rv[17:14] : rv[22:19]), $urandom, $urandom,
             12'($urandom), $urandom, $urandom, (rv[26:23] == 4'd0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule